// File: doc/BRIEF.md
# Strided Vector Load/Store Unit

This unit moves one vector between a vector register and a word-interleaved memory made of several banks. Each command gives a base word address, a stride read at issue time from a general-purpose register, a vector length and a direction. A load reads the words at base, base+stride, base+2·stride and so on. It writes them into consecutive slots of the destination vector register through a single indexed write port. A store takes the elements of a source vector register and writes them to the same strided addresses.

The memory is interleaved by word. The low address bits select a bank and the high bits select a row inside it. After an access, a bank stays unavailable for a fixed busy time. Element requests issue one per cycle, in ascending element order. A request that lands on a bank that is still busy holds the issue stream until that bank frees. Throughput therefore depends on how the stride relates to the number of banks. A stride with no common factor with the bank count visits every bank in turn. A stride that shares a factor keeps revisiting a subset of the banks.

Top module: `strided_vmem_unit`

## Requirements
- R1: After reset, busy, done, stall and vrf_we are all low.
- R2: Element i uses word address (base + i·stride) mod (NUM_BANKS·BANK_ROWS). Its bank is that address mod NUM_BANKS and its row is the address divided by NUM_BANKS. The stride is sampled together with start, and any value from 1 up is accepted.
- R3: A load writes element i to vrf_idx = i exactly once, with the word stored at that element's address. The packing does not depend on the stride.
- R4: A store writes bits [i·DATA_W +: DATA_W] of st_vec to the address of element i. A store never raises vrf_we.
- R5: A bank accessed in cycle t accepts its next access no earlier than cycle t+BUSY_CYC. A request to a busy bank waits, and it issues in the first cycle the bank is free.
- R6: At most one element issues per cycle, in ascending order, with none skipped. Stall is high in each issue cycle where the current element cannot go. The element index holds while stall is high.
- R7: When NUM_BANKS / gcd(stride, NUM_BANKS) ≥ BUSY_CYC and the banks are idle at start, a command runs with no stall cycles.
- R8: For a load, the vector register write of an element comes RD_LAT cycles after its issue, and done pulses one cycle after the last write. For a store, done pulses one cycle after the last issue. Done is high for one cycle, and busy is high from the cycle after start until done.
- R9: A start with vlen = 0 raises done in the next cycle and makes no memory access and no vector register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken while idle |
| is_store | input | 1 | 1 = store, 0 = load |
| base | input | ADDR_W | Base word address |
| stride | input | ADDR_W | Element stride in words, taken from a register |
| vlen | input | CNT_W | Vector length, 0..MAX_VL |
| st_vec | input | MAX_VL·DATA_W | Source vector register for stores, element i in bits [i·DATA_W +: DATA_W] |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| stall | output | 1 | Current element held by a busy bank |
| vrf_we | output | 1 | Vector register write enable |
| vrf_idx | output | IDX_W | Destination element slot |
| vrf_wdata | output | DATA_W | Loaded element |

## Verification
The bench builds the unit with its defaults: four banks of sixteen rows, 16-bit words, vectors of up to sixteen elements, a bank busy time of three cycles and a read latency of two. With four banks and a busy time of three, strides 1, 3 and 5 should run with no stall. Strides 2 and 6 fall short of the conflict-free bound, and strides 4 and 8 send every element to a single bank. The stall count and the completion cycle for each pattern are therefore distinct and predictable. The 64-word space is small enough that strided runs wrap the address, and it can be filled by a few unit-stride stores before the loads read it back.

// File: rtl/svm_pkg.sv
package svm_pkg;
   typedef enum logic [1:0] {
      SVM_IDLE  = 2'd0,
      SVM_ISSUE = 2'd1,
      SVM_DRAIN = 2'd2
   } svm_state_e;
endpackage

// File: rtl/svm_addr_gen.sv
module svm_addr_gen #(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  elem
);
   logic [ADDR_W-1:0] step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr   <= '0;
         elem   <= '0;
         step_q <= '0;
      end else if (load) begin
         addr   <= base;
         elem   <= '0;
         step_q <= stride;
      end else if (advance) begin
         addr <= addr + step_q;
         elem <= elem + CNT_W'(1);
      end
   end

   // R6: each issue moves to the next element only
   a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> (elem == $past(elem) + CNT_W'(1)));
endmodule

// File: rtl/svm_bank.sv
module svm_bank #(
   parameter int DATA_W   = 16,
   parameter int ROW_W    = 4,
   parameter int BUSY_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              we,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ready
);
   localparam int ROWS  = 1 << ROW_W;
   localparam int BCW   = $clog2(BUSY_CYC + 1);

   logic [DATA_W-1:0] mem [ROWS];
   logic [BCW-1:0]    busy_cnt;

   assign ready = (busy_cnt == '0);

   always_ff @(posedge clk) begin
      if (acc && we) mem[row] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         busy_cnt <= '0;
      end else begin
         if (acc && !we) rdata <= mem[row];
         if (acc)                 busy_cnt <= BCW'(BUSY_CYC - 1);
         else if (busy_cnt != '0) busy_cnt <= busy_cnt - BCW'(1);
      end
   end

   // R5: no access reaches a bank that is still occupied
   a_r5_access_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> ready);

   generate
      if (BUSY_CYC > 1) begin : g_hold
         // R5: the bank refuses the cycle right after an access
         a_r5_busy_after_access: assert property (@(posedge clk) disable iff (!rst_n)
            acc |=> !ready);
      end
   endgenerate
endmodule

// File: rtl/svm_rdpipe.sv
module svm_rdpipe #(
   parameter int DATA_W    = 16,
   parameter int IDX_W     = 4,
   parameter int NUM_BANKS = 4,
   parameter int RD_LAT    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_vld,
   input  logic [IDX_W-1:0]            in_idx,
   input  logic [$clog2(NUM_BANKS)-1:0] in_sel,
   input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
   output logic                        out_vld,
   output logic [IDX_W-1:0]            out_idx,
   output logic [DATA_W-1:0]           out_data
);
   localparam int SEL_W = $clog2(NUM_BANKS);

   logic              v0;
   logic [IDX_W-1:0]  i0;
   logic [SEL_W-1:0]  s0;
   logic [DATA_W-1:0] d0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v0 <= 1'b0;
         i0 <= '0;
         s0 <= '0;
      end else begin
         v0 <= in_vld;
         if (in_vld) begin
            i0 <= in_idx;
            s0 <= in_sel;
         end
      end
   end

   assign d0 = bank_rdata[DATA_W*int'(s0) +: DATA_W];

   generate
      if (RD_LAT == 1) begin : g_direct
         assign out_vld  = v0;
         assign out_idx  = i0;
         assign out_data = d0;
      end else begin : g_stages
         localparam int NS = RD_LAT - 1;
         logic [NS-1:0]             vp;
         logic [NS-1:0][IDX_W-1:0]  ip;
         logic [NS-1:0][DATA_W-1:0] dp;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vp <= '0;
               ip <= '0;
               dp <= '0;
            end else begin
               vp[0] <= v0;
               ip[0] <= i0;
               dp[0] <= d0;
               for (int k = 1; k < NS; k++) begin
                  vp[k] <= vp[k-1];
                  ip[k] <= ip[k-1];
                  dp[k] <= dp[k-1];
               end
            end
         end
         assign out_vld  = vp[NS-1];
         assign out_idx  = ip[NS-1];
         assign out_data = dp[NS-1];
      end
   endgenerate
endmodule

// File: rtl/strided_vmem_unit.sv
module strided_vmem_unit
   import svm_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_ROWS = 16,
   parameter int DATA_W    = 16,
   parameter int MAX_VL    = 16,
   parameter int BUSY_CYC  = 3,
   parameter int RD_LAT    = 2,
   localparam int BANK_W   = $clog2(NUM_BANKS),
   localparam int ROW_W    = $clog2(BANK_ROWS),
   localparam int ADDR_W   = BANK_W + ROW_W,
   localparam int CNT_W    = $clog2(MAX_VL + 1),
   localparam int IDX_W    = $clog2(MAX_VL)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     is_store,
   input  logic [ADDR_W-1:0]        base,
   input  logic [ADDR_W-1:0]        stride,
   input  logic [CNT_W-1:0]         vlen,
   input  logic [MAX_VL*DATA_W-1:0] st_vec,
   output logic                     busy,
   output logic                     done,
   output logic                     stall,
   output logic                     vrf_we,
   output logic [IDX_W-1:0]         vrf_idx,
   output logic [DATA_W-1:0]        vrf_wdata
);
   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (BANK_ROWS < 2 || (BANK_ROWS & (BANK_ROWS - 1)) != 0) begin : g_bad_rows
         $error("BANK_ROWS must be a power of two of at least 2");
      end
      if (MAX_VL < 2) begin : g_bad_vl
         $error("MAX_VL must be at least 2");
      end
      if (BUSY_CYC < 1 || RD_LAT < 1) begin : g_bad_time
         $error("BUSY_CYC and RD_LAT must be at least 1");
      end
   endgenerate

   svm_state_e               state_q;
   logic                     store_q;
   logic [CNT_W-1:0]         vlen_q;
   logic                     done_q;

   logic [ADDR_W-1:0]        cur_addr;
   logic [CNT_W-1:0]         cur_elem;
   logic [BANK_W-1:0]        tgt_bank;
   logic [ROW_W-1:0]         tgt_row;
   logic [NUM_BANKS-1:0]     bank_ready;
   logic [NUM_BANKS-1:0]     bank_acc;
   logic [NUM_BANKS*DATA_W-1:0] bank_rd;
   logic [DATA_W-1:0]        st_elem;
   logic                     accept, issuing, fire, last_fire;
   logic                     rp_vld;
   logic [IDX_W-1:0]         rp_idx;
   logic [DATA_W-1:0]        rp_data;
   logic                     rp_last;

   assign accept    = (state_q == SVM_IDLE) && start;
   assign issuing   = (state_q == SVM_ISSUE);
   assign tgt_bank  = cur_addr[BANK_W-1:0];
   assign tgt_row   = cur_addr[ADDR_W-1:BANK_W];
   assign fire      = issuing && bank_ready[tgt_bank];
   assign last_fire = fire && (cur_elem == vlen_q - CNT_W'(1));
   assign st_elem   = st_vec[DATA_W*int'(cur_elem[IDX_W-1:0]) +: DATA_W];
   assign rp_last   = rp_vld && (CNT_W'(rp_idx) == vlen_q - CNT_W'(1));

   svm_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_agen (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .advance (fire),
      .base    (base),
      .stride  (stride),
      .addr    (cur_addr),
      .elem    (cur_elem)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         assign bank_acc[b] = fire && (tgt_bank == BANK_W'(b));
         svm_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .BUSY_CYC(BUSY_CYC)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .acc   (bank_acc[b]),
            .we    (store_q),
            .row   (tgt_row),
            .wdata (st_elem),
            .rdata (bank_rd[b*DATA_W +: DATA_W]),
            .ready (bank_ready[b])
         );
      end
   endgenerate

   svm_rdpipe #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS), .RD_LAT(RD_LAT)) u_rpipe (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_vld     (fire && !store_q),
      .in_idx     (cur_elem[IDX_W-1:0]),
      .in_sel     (tgt_bank),
      .bank_rdata (bank_rd),
      .out_vld    (rp_vld),
      .out_idx    (rp_idx),
      .out_data   (rp_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SVM_IDLE;
         store_q <= 1'b0;
         vlen_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SVM_IDLE: if (start) begin
               store_q <= is_store;
               vlen_q  <= vlen;
               if (vlen == '0) done_q  <= 1'b1;
               else            state_q <= SVM_ISSUE;
            end
            SVM_ISSUE: if (last_fire) begin
               if (store_q) begin
                  done_q  <= 1'b1;
                  state_q <= SVM_IDLE;
               end else begin
                  state_q <= SVM_DRAIN;
               end
            end
            SVM_DRAIN: if (rp_last) begin
               done_q  <= 1'b1;
               state_q <= SVM_IDLE;
            end
            default: state_q <= SVM_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SVM_IDLE);
   assign done      = done_q;
   assign stall     = issuing && !fire;
   assign vrf_we    = rp_vld;
   assign vrf_idx   = rp_idx;
   assign vrf_wdata = rp_data;

   // R6: a single bank is touched per cycle at most
   a_r6_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_acc));
   // R6: a held element keeps its index
   a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(cur_elem));
   // R8: done lasts one cycle and leaves the unit idle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy ##1 !done));
   // R3: written slots stay inside the vector
   a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      vrf_we |-> (CNT_W'(vrf_idx) < vlen_q));
   // R4: stores never write the vector register
   a_r4_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && store_q) |-> !vrf_we);
   // R9: zero length finishes at once without touching a bank
   a_r9_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && vlen == '0) |=> (done && !busy && bank_acc == '0));
   // R2: commands stay within the supported length
   a_r2_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (vlen <= CNT_W'(MAX_VL)));
endmodule

// File: tb/test_strided_vmem_unit.sv
module test_strided_vmem_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NB   = 4;
   localparam int ROWS = 16;
   localparam int DW   = 16;
   localparam int MVL  = 16;
   localparam int BUSY = 3;
   localparam int LAT  = 2;
   localparam int WORDS = NB * ROWS;
   localparam int NV   = 14;

   typedef struct packed {
      logic       st;
      logic [5:0] base;
      logic [5:0] stride;
      logic [4:0] vl;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{1'b1, 6'd0,  6'd1, 5'd16},
      '{1'b1, 6'd16, 6'd1, 5'd16},
      '{1'b1, 6'd32, 6'd1, 5'd16},
      '{1'b1, 6'd48, 6'd1, 5'd16},
      '{1'b0, 6'd0,  6'd1, 5'd16},
      '{1'b0, 6'd3,  6'd5, 5'd16},
      '{1'b0, 6'd1,  6'd2, 5'd8},
      '{1'b0, 6'd0,  6'd4, 5'd6},
      '{1'b1, 6'd7,  6'd3, 5'd10},
      '{1'b0, 6'd7,  6'd3, 5'd10},
      '{1'b1, 6'd2,  6'd8, 5'd5},
      '{1'b0, 6'd2,  6'd8, 5'd5},
      '{1'b0, 6'd0,  6'd6, 5'd16},
      '{1'b0, 6'd63, 6'd7, 5'd1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic is_store = 1'b0;
   logic [5:0] base = '0;
   logic [5:0] stride = '0;
   logic [4:0] vlen = '0;
   logic [MVL*DW-1:0] st_vec = '0;
   logic busy, done, stall, vrf_we;
   logic [3:0] vrf_idx;
   logic [DW-1:0] vrf_wdata;

   int n_cmp = 0;
   int n_bad = 0;
   int shadow [WORDS];

   always #(CLK_PERIOD/2) clk = ~clk;

   strided_vmem_unit #(
      .NUM_BANKS(NB), .BANK_ROWS(ROWS), .DATA_W(DW),
      .MAX_VL(MVL), .BUSY_CYC(BUSY), .RD_LAT(LAT)
   ) i_strided_vmem_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
      .base(base), .stride(stride), .vlen(vlen), .st_vec(st_vec),
      .busy(busy), .done(done), .stall(stall), .vrf_we(vrf_we),
      .vrf_idx(vrf_idx), .vrf_wdata(vrf_wdata)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int gcd(input int a, input int b);
      int x = a;
      int y = b;
      while (y != 0) begin
         int t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   function automatic int eaddr(input int b, input int s, input int i);
      return (b + i * s) % WORDS;
   endfunction

   // issue-time model from R5/R6/R8/R9, banks idle at start
   task automatic model(input int st, input int b, input int s, input int vl,
                        output int n_done, output int n_stall);
      int fr [NB];
      int t = 1;
      int last = 0;
      for (int k = 0; k < NB; k++) fr[k] = 0;
      for (int i = 0; i < vl; i++) begin
         int bk = eaddr(b, s, i) % NB;
         int ti = (fr[bk] > t) ? fr[bk] : t;
         fr[bk] = ti + BUSY;
         t = ti + 1;
         last = ti;
      end
      if (vl == 0) begin
         n_done  = 0;
         n_stall = 0;
      end else begin
         n_stall = last - vl;
         n_done  = st ? last : last + LAT;
      end
   endtask

   task automatic run_op(input logic st, input int b, input int s, input int vl, input int tag);
      int exp_n, exp_st;
      int n = 0;
      int stalls = 0;
      int writes = 0;
      int got [MVL];
      for (int i = 0; i < MVL; i++) begin
         got[i] = -1;
         st_vec[i*DW +: DW] = DW'((tag + 1) * 256 + i * 7 + 3);
      end
      model(int'(st), b, s, vl, exp_n, exp_st);
      @(negedge clk);
      start    = 1'b1;
      is_store = st;
      base     = 6'(b);
      stride   = 6'(s);
      vlen     = 5'(vl);
      @(negedge clk);
      start = 1'b0;
      forever begin
         if (stall) stalls++;
         if (vrf_we) begin
            writes++;
            got[vrf_idx] = int'(vrf_wdata);
         end
         if (done || n > 400) break;
         @(negedge clk);
         n++;
      end
      chk($sformatf("R5 R8 done cycle, op %0d", tag), n, exp_n);
      chk($sformatf("R6 stall cycles, op %0d", tag), stalls, exp_st);
      if (vl > 0 && (NB / gcd(s, NB)) >= BUSY)
         chk($sformatf("R7 conflict-free stride %0d, op %0d", s, tag), stalls, 0);
      if (vl == 0) begin
         chk($sformatf("R9 zero length writes, op %0d", tag), writes, 0);
      end else if (st) begin
         chk($sformatf("R4 store vrf writes, op %0d", tag), writes, 0);
         for (int i = 0; i < vl; i++)
            shadow[eaddr(b, s, i)] = int'(st_vec[i*DW +: DW]);
      end else begin
         chk($sformatf("R3 write count, op %0d", tag), writes, vl);
         for (int i = 0; i < vl; i++)
            chk($sformatf("R2 R3 slot %0d data, op %0d", i, tag), got[i], shadow[eaddr(b, s, i)]);
      end
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < WORDS; i++) shadow[i] = -1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 done after reset", int'(done), 0);
      chk("R1 stall after reset", int'(stall), 0);
      chk("R1 vrf_we after reset", int'(vrf_we), 0);

      for (int v = 0; v < NV; v++)
         run_op(VECS[v].st, int'(VECS[v].base), int'(VECS[v].stride), int'(VECS[v].vl), v);

      // R9: zero-length load and store, then memory read back unchanged
      run_op(1'b0, 5, 3, 0, 20);
      run_op(1'b1, 0, 1, 0, 21);
      run_op(1'b0, 0, 1, 4, 22);
      // single-bank store and read back with the largest stride step
      run_op(1'b1, 1, 16, 4, 23);
      run_op(1'b0, 1, 16, 4, 24);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule